// File: doc/BRIEF.md
# Secure Address Region Firewall

This block sits between the bus masters of a subsystem and one memory or peripheral slave, and filters every read and write request by its security attribute. A small table of programmable regions, each with an aligned base, a power-of-two size, an enable and a secure-only flag, decides which addresses a non-secure master may reach. Secure requests always pass. A non-secure request passes only if its address falls in an enabled region that is not marked secure-only. A request that fails is never presented to the slave. Instead, the requester sees an error pulse on the following cycle, and the first such failure since reset is captured in a sticky fault record.

The read and write channels each carry their own non-secure bit. A value of 1 means non-secure and 0 means secure, which follows the common AXI protection convention. The two channels are judged independently in the same cycle. The region table is programmed one entry per write through a narrow configuration port. Only secure configuration writes are honoured. Once the boot lock input has been seen high at any clock edge, the table is frozen until the next reset.

Top module: `sec_region_firewall`

## Requirements
- R1: After reset every region is disabled, `rd_err`, `wr_err` and `fault_valid` are 0, and therefore any non-secure request is refused.
- R2: A non-secure request (nonsec bit = 1) that is not permitted is not forwarded (`slv_*_valid` stays 0 in the request cycle), and the matching `*_err` output is 1 for exactly the next cycle.
- R3: A non-secure request whose address hits an enabled region with secure-only = 0 is forwarded in the same cycle with its address, data and nonsec bit unchanged, and produces no error.
- R4: A secure request (nonsec bit = 0) is forwarded whatever the address, including unmapped addresses and secure-only regions.
- R5: A region with size field S covers the 2^S bytes starting at its base with the low S bits cleared; the low S bits of the programmed base are ignored.
- R6: When several enabled regions contain an address, the one with the lowest index alone decides the outcome.
- R7: The read and write channels are checked independently; a refusal on one does not affect a request on the other in the same cycle.
- R8: A region whose enable bit is 0 matches nothing, so its addresses behave as unmapped (secure-only).
- R9: A configuration write with `cfg_nonsec` = 1 has no effect on the region table.
- R10: Once `boot_lock` is 1 at a rising clock edge, that write and every later configuration write is refused, even after `boot_lock` returns to 0, until reset.
- R11: The first refused request after reset sets `fault_valid`, stores its address in `fault_addr` and its direction in `fault_is_write` (1 = write). When both channels fail in the same cycle, the read is recorded. The record does not change until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_nonsec | input | 1 | Security bit of the configuration write (1 = non-secure) |
| cfg_idx | input | IDX_W | Region index written |
| cfg_base | input | ADDR_W | Region base address |
| cfg_size_log2 | input | SZ_W | Log2 of region size in bytes |
| cfg_enable | input | 1 | Region enable |
| cfg_secure_only | input | 1 | Region refuses non-secure requests |
| boot_lock | input | 1 | Freezes the configuration from the edge it is seen |
| rd_req_valid | input | 1 | Read request from master |
| rd_req_addr | input | ADDR_W | Read address |
| rd_req_nonsec | input | 1 | Read security bit (1 = non-secure) |
| wr_req_valid | input | 1 | Write request from master |
| wr_req_addr | input | ADDR_W | Write address |
| wr_req_data | input | DATA_W | Write data |
| wr_req_nonsec | input | 1 | Write security bit (1 = non-secure) |
| slv_rd_valid | output | 1 | Read forwarded to slave |
| slv_rd_addr | output | ADDR_W | Forwarded read address |
| slv_rd_nonsec | output | 1 | Forwarded read security bit |
| slv_wr_valid | output | 1 | Write forwarded to slave |
| slv_wr_addr | output | ADDR_W | Forwarded write address |
| slv_wr_data | output | DATA_W | Forwarded write data |
| slv_wr_nonsec | output | 1 | Forwarded write security bit |
| rd_err | output | 1 | Error response for a refused read, one cycle after it |
| wr_err | output | 1 | Error response for a refused write, one cycle after it |
| fault_valid | output | 1 | Sticky: a request has been refused |
| fault_addr | output | ADDR_W | Address of the first refused request |
| fault_is_write | output | 1 | Direction of the first refused request (1 = write) |

## Verification
The bench places a small secure-only region inside a larger open one. If the priority were wrong, non-secure requests would slip into the small region or be refused from the large one. Requests sit on the last byte of a region and the first byte past it, and one region is programmed with a misaligned base. A match that used the wrong mask would then let the byte past the end through or miss the region altogether. A disabled region, a non-secure configuration write, and a write issued in the same edge as the lock pulse, and again after the lock drops, must all leave the access outcome unchanged. A design that honoured any of them would open an address it should not. Simultaneous failures on both channels check that the fault record keeps the read and never overwrites it with a later failure.

// File: rtl/fw_pkg.sv
package fw_pkg;

   localparam int unsigned FW_MAX_ADDR_W = 64;

   typedef enum logic {
      FW_DIR_READ  = 1'b0,
      FW_DIR_WRITE = 1'b1
   } fw_dir_e;

   // Mask that keeps address bits at or above position lg.
   function automatic logic [FW_MAX_ADDR_W-1:0] fw_keep_mask(input int unsigned lg);
      logic [FW_MAX_ADDR_W-1:0] m;
      for (int unsigned i = 0; i < FW_MAX_ADDR_W; i++)
         m[i] = (i >= lg);
      return m;
   endfunction

endpackage

// File: rtl/fw_region_table.sv
module fw_region_table #(
   parameter int unsigned NUM_REGIONS = 8,
   parameter int unsigned ADDR_W      = 32,
   localparam int unsigned IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
   localparam int unsigned SZ_W       = $clog2(ADDR_W + 1)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                cfg_we,
   input  logic                                cfg_nonsec,
   input  logic [IDX_W-1:0]                    cfg_idx,
   input  logic [ADDR_W-1:0]                   cfg_base,
   input  logic [SZ_W-1:0]                     cfg_size_log2,
   input  logic                                cfg_enable,
   input  logic                                cfg_secure_only,
   input  logic                                boot_lock,
   output logic [NUM_REGIONS-1:0][ADDR_W-1:0]  base_o,
   output logic [NUM_REGIONS-1:0][SZ_W-1:0]    size_o,
   output logic [NUM_REGIONS-1:0]              en_o,
   output logic [NUM_REGIONS-1:0]              sec_o
);

   logic locked_q;
   logic wr_ok;

   assign wr_ok = cfg_we && !cfg_nonsec && !locked_q && !boot_lock
                  && (int'(cfg_idx) < int'(NUM_REGIONS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) locked_q <= 1'b0;
      else if (boot_lock) locked_q <= 1'b1;
   end

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_o[g] <= '0;
            size_o[g] <= '0;
            en_o[g]   <= 1'b0;
            sec_o[g]  <= 1'b1;
         end else if (wr_ok && (int'(cfg_idx) == g)) begin
            base_o[g] <= cfg_base;
            size_o[g] <= cfg_size_log2;
            en_o[g]   <= cfg_enable;
            sec_o[g]  <= cfg_secure_only;
         end
      end
   end

   a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> locked_q);

   a_r10_table_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> ($stable(base_o) && $stable(size_o) && $stable(en_o) && $stable(sec_o)));

   a_r9_nonsec_cfg_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_nonsec) |=> ($stable(base_o) && $stable(en_o) && $stable(sec_o)));

endmodule

// File: rtl/fw_lookup.sv
module fw_lookup
   import fw_pkg::*;
#(
   parameter int unsigned NUM_REGIONS = 8,
   parameter int unsigned ADDR_W      = 32,
   localparam int unsigned IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
   localparam int unsigned SZ_W       = $clog2(ADDR_W + 1)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [ADDR_W-1:0]                   addr_i,
   input  logic                                nonsec_i,
   input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]  base_i,
   input  logic [NUM_REGIONS-1:0][SZ_W-1:0]    size_i,
   input  logic [NUM_REGIONS-1:0]              en_i,
   input  logic [NUM_REGIONS-1:0]              sec_i,
   output logic                                allow_o
);

   logic [NUM_REGIONS-1:0] match;
   logic                   hit;
   logic [IDX_W-1:0]       hit_idx;
   logic                   hit_sec;

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
      logic [ADDR_W-1:0] keep;
      assign keep     = ADDR_W'(fw_keep_mask(int'(size_i[g])));
      assign match[g] = en_i[g] && (((addr_i ^ base_i[g]) & keep) == '0);
   end

   // Descending scan: the last assignment, the lowest index, wins.
   always_comb begin
      hit     = 1'b0;
      hit_idx = '0;
      hit_sec = 1'b1;
      for (int k = NUM_REGIONS - 1; k >= 0; k--) begin
         if (match[k]) begin
            hit     = 1'b1;
            hit_idx = IDX_W'(k);
            hit_sec = sec_i[k];
         end
      end
   end

   assign allow_o = !nonsec_i || (hit && !hit_sec);

   a_r8_hit_is_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> en_i[hit_idx]);

   a_r4_secure_allowed: assert property (@(posedge clk) disable iff (!rst_n)
      !nonsec_i |-> allow_o);

endmodule

// File: rtl/fw_fault_log.sv
module fw_fault_log
   import fw_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_deny_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic              wr_deny_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   output logic              rd_err_o,
   output logic              wr_err_o,
   output logic              fault_valid_o,
   output logic [ADDR_W-1:0] fault_addr_o,
   output fw_dir_e           fault_dir_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_err_o      <= 1'b0;
         wr_err_o      <= 1'b0;
         fault_valid_o <= 1'b0;
         fault_addr_o  <= '0;
         fault_dir_o   <= FW_DIR_READ;
      end else begin
         rd_err_o <= rd_deny_i;
         wr_err_o <= wr_deny_i;
         if (!fault_valid_o && (rd_deny_i || wr_deny_i)) begin
            fault_valid_o <= 1'b1;
            fault_addr_o  <= rd_deny_i ? rd_addr_i : wr_addr_i;
            fault_dir_o   <= rd_deny_i ? FW_DIR_READ : FW_DIR_WRITE;
         end
      end
   end

   a_r11_fault_held: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid_o |=> (fault_valid_o && $stable(fault_addr_o) && $stable(fault_dir_o)));

endmodule

// File: rtl/sec_region_firewall.sv
module sec_region_firewall
   import fw_pkg::*;
#(
   parameter int unsigned NUM_REGIONS = 8,
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned DATA_W      = 32,
   localparam int unsigned IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
   localparam int unsigned SZ_W       = $clog2(ADDR_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_nonsec,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [SZ_W-1:0]   cfg_size_log2,
   input  logic              cfg_enable,
   input  logic              cfg_secure_only,
   input  logic              boot_lock,
   input  logic              rd_req_valid,
   input  logic [ADDR_W-1:0] rd_req_addr,
   input  logic              rd_req_nonsec,
   input  logic              wr_req_valid,
   input  logic [ADDR_W-1:0] wr_req_addr,
   input  logic [DATA_W-1:0] wr_req_data,
   input  logic              wr_req_nonsec,
   output logic              slv_rd_valid,
   output logic [ADDR_W-1:0] slv_rd_addr,
   output logic              slv_rd_nonsec,
   output logic              slv_wr_valid,
   output logic [ADDR_W-1:0] slv_wr_addr,
   output logic [DATA_W-1:0] slv_wr_data,
   output logic              slv_wr_nonsec,
   output logic              rd_err,
   output logic              wr_err,
   output logic              fault_valid,
   output logic [ADDR_W-1:0] fault_addr,
   output logic              fault_is_write
);

   if (NUM_REGIONS < 1 || NUM_REGIONS > 64) begin : g_bad_regions
      $error("sec_region_firewall: NUM_REGIONS must be 1..64");
   end
   if (ADDR_W < 8 || ADDR_W > FW_MAX_ADDR_W) begin : g_bad_addr
      $error("sec_region_firewall: ADDR_W must be 8..64");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("sec_region_firewall: DATA_W must be positive");
   end

   logic [NUM_REGIONS-1:0][ADDR_W-1:0] tbl_base;
   logic [NUM_REGIONS-1:0][SZ_W-1:0]   tbl_size;
   logic [NUM_REGIONS-1:0]             tbl_en;
   logic [NUM_REGIONS-1:0]             tbl_sec;
   logic                               rd_allow, wr_allow;
   fw_dir_e                            fault_dir;

   fw_region_table #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) u_table (
      .clk             (clk),
      .rst_n           (rst_n),
      .cfg_we          (cfg_we),
      .cfg_nonsec      (cfg_nonsec),
      .cfg_idx         (cfg_idx),
      .cfg_base        (cfg_base),
      .cfg_size_log2   (cfg_size_log2),
      .cfg_enable      (cfg_enable),
      .cfg_secure_only (cfg_secure_only),
      .boot_lock       (boot_lock),
      .base_o          (tbl_base),
      .size_o          (tbl_size),
      .en_o            (tbl_en),
      .sec_o           (tbl_sec)
   );

   fw_lookup #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) u_rd_lookup (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_i   (rd_req_addr),
      .nonsec_i (rd_req_nonsec),
      .base_i   (tbl_base),
      .size_i   (tbl_size),
      .en_i     (tbl_en),
      .sec_i    (tbl_sec),
      .allow_o  (rd_allow)
   );

   fw_lookup #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) u_wr_lookup (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_i   (wr_req_addr),
      .nonsec_i (wr_req_nonsec),
      .base_i   (tbl_base),
      .size_i   (tbl_size),
      .en_i     (tbl_en),
      .sec_i    (tbl_sec),
      .allow_o  (wr_allow)
   );

   fw_fault_log #(.ADDR_W(ADDR_W)) u_fault (
      .clk           (clk),
      .rst_n         (rst_n),
      .rd_deny_i     (rd_req_valid && !rd_allow),
      .rd_addr_i     (rd_req_addr),
      .wr_deny_i     (wr_req_valid && !wr_allow),
      .wr_addr_i     (wr_req_addr),
      .rd_err_o      (rd_err),
      .wr_err_o      (wr_err),
      .fault_valid_o (fault_valid),
      .fault_addr_o  (fault_addr),
      .fault_dir_o   (fault_dir)
   );

   assign slv_rd_valid   = rd_req_valid && rd_allow;
   assign slv_rd_addr    = rd_req_addr;
   assign slv_rd_nonsec  = rd_req_nonsec;
   assign slv_wr_valid   = wr_req_valid && wr_allow;
   assign slv_wr_addr    = wr_req_addr;
   assign slv_wr_data    = wr_req_data;
   assign slv_wr_nonsec  = wr_req_nonsec;
   assign fault_is_write = (fault_dir == FW_DIR_WRITE);

   a_r2_rd_err_only_after_block: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |-> ($past(rd_req_valid) && !$past(slv_rd_valid)));

   a_r2_wr_err_only_after_block: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> ($past(wr_req_valid) && !$past(slv_wr_valid)));

   a_r4_secure_read_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_valid && !rd_req_nonsec) |-> slv_rd_valid);

   a_r2_blocked_read_errors: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_valid && !slv_rd_valid) |=> rd_err);

endmodule

// File: tb/sec_region_firewall_test.sv
module sec_region_firewall_test;

   localparam int unsigned NR = 8;
   localparam int unsigned AW = 32;
   localparam int unsigned DW = 32;
   localparam int unsigned IW = $clog2(NR);
   localparam int unsigned SW = $clog2(AW + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 0, cfg_nonsec = 0, cfg_enable = 0, cfg_secure_only = 0, boot_lock = 0;
   logic [IW-1:0] cfg_idx = '0;
   logic [AW-1:0] cfg_base = '0;
   logic [SW-1:0] cfg_size_log2 = '0;
   logic rd_req_valid = 0, rd_req_nonsec = 0, wr_req_valid = 0, wr_req_nonsec = 0;
   logic [AW-1:0] rd_req_addr = '0, wr_req_addr = '0;
   logic [DW-1:0] wr_req_data = '0;
   logic slv_rd_valid, slv_rd_nonsec, slv_wr_valid, slv_wr_nonsec;
   logic [AW-1:0] slv_rd_addr, slv_wr_addr, fault_addr;
   logic [DW-1:0] slv_wr_data;
   logic rd_err, wr_err, fault_valid, fault_is_write;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sec_region_firewall #(.NUM_REGIONS(NR), .ADDR_W(AW), .DATA_W(DW)) uut (.*);

   task automatic check(input logic ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic cfg_write(input int idx, input logic [AW-1:0] base, input int sz,
                            input logic en, input logic so, input logic ns, input logic lk);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_base = base; cfg_size_log2 = SW'(sz);
      cfg_enable = en; cfg_secure_only = so; cfg_nonsec = ns; boot_lock = lk;
      @(negedge clk);
      cfg_we = 1'b0; cfg_nonsec = 1'b0; boot_lock = 1'b0;
   endtask

   // Drives one cycle of requests and checks forwarding, then the error responses.
   task automatic access(input logic rv, input logic [AW-1:0] ra, input logic rns,
                         input logic wv, input logic [AW-1:0] wa, input logic wns,
                         input logic erf, input logic ewf, input string tag);
      logic [DW-1:0] d;
      @(negedge clk);
      d = wa ^ 32'hA5A5_0000;
      rd_req_valid = rv; rd_req_addr = ra; rd_req_nonsec = rns;
      wr_req_valid = wv; wr_req_addr = wa; wr_req_nonsec = wns; wr_req_data = d;
      #2;
      check(slv_rd_valid == erf, {tag, " rd forward"}, 64'(slv_rd_valid), 64'(erf));
      check(slv_wr_valid == ewf, {tag, " wr forward"}, 64'(slv_wr_valid), 64'(ewf));
      if (erf) check(slv_rd_addr == ra && slv_rd_nonsec == rns, {tag, " R3 rd passthrough"},
                     64'(slv_rd_addr), 64'(ra));
      if (ewf) check(slv_wr_addr == wa && slv_wr_data == d && slv_wr_nonsec == wns,
                     {tag, " R3 wr passthrough"}, 64'(slv_wr_data), 64'(d));
      @(posedge clk);
      #1;
      rd_req_valid = 1'b0; wr_req_valid = 1'b0;
      check(rd_err == (rv && !erf), {tag, " R2 rd_err"}, 64'(rd_err), 64'(rv && !erf));
      check(wr_err == (wv && !ewf), {tag, " R2 wr_err"}, 64'(wr_err), 64'(wv && !ewf));
      @(posedge clk);
      #1;
      check(!rd_err && !wr_err, {tag, " R2 err one cycle"}, 64'({rd_err, wr_err}), 64'(0));
   endtask

   typedef struct packed {
      logic        rv;
      logic [31:0] ra;
      logic        rns;
      logic        wv;
      logic [31:0] wa;
      logic        wns;
      logic        erf;
      logic        ewf;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 32'h0000_1080, 1'b1, 1'b1, 32'h0000_1800, 1'b1, 1'b0, 1'b1}, // R6 R7
      '{1'b1, 32'h0000_1800, 1'b1, 1'b1, 32'h0000_1080, 1'b1, 1'b1, 1'b0}, // R6 R7
      '{1'b1, 32'h0002_0000, 1'b1, 1'b1, 32'h0002_FFFF, 1'b1, 1'b1, 1'b1}, // R5 R3
      '{1'b1, 32'h0003_0000, 1'b1, 1'b1, 32'h0000_0FFF, 1'b1, 1'b0, 1'b0}, // R5 past ends
      '{1'b1, 32'h0000_4004, 1'b1, 1'b1, 32'h0000_4004, 1'b0, 1'b0, 1'b1}, // R8 R4
      '{1'b1, 32'h0003_0000, 1'b0, 1'b1, 32'h0000_1080, 1'b0, 1'b1, 1'b1}, // R4
      '{1'b0, 32'h0000_1800, 1'b1, 1'b1, 32'h0000_2000, 1'b1, 1'b0, 1'b0}, // R5 R7
      '{1'b1, 32'h0000_1FFF, 1'b1, 1'b0, 32'h0000_0000, 1'b1, 1'b1, 1'b0}  // R5 last byte
   };

   initial begin
      do_reset();
      #1;
      // R1: reset state
      check(!rd_err && !wr_err && !fault_valid, "R1 reset outputs", 64'({rd_err, wr_err, fault_valid}), 64'(0));
      // R1 R11: both channels refused together, read recorded
      access(1'b1, 32'h50, 1'b1, 1'b1, 32'h60, 1'b1, 1'b0, 1'b0, "R1 unmapped");
      check(fault_valid && fault_addr == 32'h50 && !fault_is_write, "R11 tie read recorded",
            64'(fault_addr), 64'h50);
      access(1'b0, 32'h0, 1'b0, 1'b1, 32'h70, 1'b1, 1'b0, 1'b0, "R11 later");
      check(fault_addr == 32'h50 && !fault_is_write, "R11 record held", 64'(fault_addr), 64'h50);

      do_reset();
      #1;
      check(!fault_valid, "R1 fault cleared by reset", 64'(fault_valid), 64'(0));
      cfg_write(0, 32'h0000_1000, 8,  1'b1, 1'b1, 1'b0, 1'b0);
      cfg_write(1, 32'h0000_1000, 12, 1'b1, 1'b0, 1'b0, 1'b0);
      cfg_write(2, 32'h0002_1234, 16, 1'b1, 1'b0, 1'b0, 1'b0);
      cfg_write(3, 32'h0000_4000, 4,  1'b0, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < NV; i++)
         access(VECS[i].rv, VECS[i].ra, VECS[i].rns, VECS[i].wv, VECS[i].wa, VECS[i].wns,
                VECS[i].erf, VECS[i].ewf, $sformatf("vec%0d", i));
      check(fault_valid && fault_addr == 32'h1080 && !fault_is_write, "R11 first fault kept",
            64'(fault_addr), 64'h1080);

      // R9: non-secure configuration write ignored
      cfg_write(4, 32'h0000_8000, 8, 1'b1, 1'b0, 1'b1, 1'b0);
      access(1'b1, 32'h8000, 1'b1, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0, "R9 nonsec cfg");
      cfg_write(4, 32'h0000_8000, 8, 1'b1, 1'b0, 1'b0, 1'b0);
      access(1'b1, 32'h8000, 1'b1, 1'b0, 32'h0, 1'b1, 1'b1, 1'b0, "R9 secure cfg");

      // R10: write in the lock cycle, and after lock drops, both refused
      cfg_write(5, 32'h0000_9000, 8, 1'b1, 1'b0, 1'b0, 1'b1);
      access(1'b0, 32'h0, 1'b1, 1'b1, 32'h9000, 1'b1, 1'b0, 1'b0, "R10 lock edge");
      cfg_write(5, 32'h0000_9000, 8, 1'b1, 1'b0, 1'b0, 1'b0);
      access(1'b0, 32'h0, 1'b1, 1'b1, 32'h9000, 1'b1, 1'b0, 1'b0, "R10 after lock");
      cfg_write(4, 32'h0000_8000, 8, 1'b1, 1'b1, 1'b0, 1'b0);
      access(1'b1, 32'h8000, 1'b1, 1'b0, 32'h0, 1'b1, 1'b1, 1'b0, "R10 region kept");

      // R10: reset releases the lock
      do_reset();
      cfg_write(5, 32'h0000_9000, 8, 1'b1, 1'b0, 1'b0, 1'b0);
      access(1'b1, 32'h90FF, 1'b1, 1'b1, 32'h9000, 1'b1, 1'b1, 1'b1, "R10 reset unlocks");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule